// File: doc/BRIEF.md
# PHY Test-Port Serial Master

This block drives the configuration test port of a high-speed serial PHY. The port has four signals: a test clock, a test enable, an 8-bit data-in bus and an 8-bit data-out bus. A sequencer or a software-facing wrapper raises a request with a direction bit, an 8-bit test code and, for writes, an 8-bit data byte. The block then moves the port pins through a fixed sequence of single-pin changes. It first selects the internal register with the code, then transfers the data byte, and at the end it returns the byte the PHY presents on data-out.

A write transfers the given byte and returns the monitored data-out byte once the data transfer is finished. A read first samples data-out just after the code has been selected. It then writes that sampled byte back in the data transfer, so the register keeps its value, and it returns the sampled byte. Each pin change is followed by a settle interval of `DWELL_CYCLES` system clocks. No pin changes inside that interval. A busy/done handshake frames every transaction.

Top module: `phy_test_master`

## Requirements
- R1: After reset, `tclk_o`, `ten_o`, `tdin_o`, `busy_o` and `done_o` are all 0.
- R2: The code phase makes these changes in order: `tclk_o` goes to 1, `tdin_o` takes the test code, `ten_o` goes to 1, `tclk_o` goes to 0, `ten_o` goes to 0.
- R3: The data phase follows the code phase and makes these changes in order: `tclk_o` goes to 0, `tdin_o` takes the data byte, `tclk_o` goes to 1. After the transaction `tclk_o` stays at 1.
- R4: When `we_i`=1 (write), `tdin_o` carries `wdata_i` in the data phase. `tdout_i` is sampled one dwell after the final rise of `tclk_o`, and that byte appears on `rdata_o` when `done_o` pulses.
- R5: When `we_i`=0 (read), `tdout_i` is sampled one dwell after `ten_o` falls. That byte is driven on `tdin_o` in the data phase and appears on `rdata_o` when `done_o` pulses.
- R6: Each of the eight steps lasts exactly `DWELL_CYCLES` clocks. At most one of `tclk_o`, `ten_o`, `tdin_o` changes at any clock edge, and all three are held between step boundaries.
- R7: A request (`req_i`=1 at a clock edge) is accepted only while `busy_o`=0. A request while busy has no effect on the pins, the timing or the result.
- R8: `busy_o` rises in the cycle after acceptance and stays high for 8*`DWELL_CYCLES` cycles. It falls in the same cycle that `done_o` pulses high for exactly one cycle. `rdata_o` then holds its value until the next completion.
- R9: `ten_o` rises only while `tclk_o` is 1 and falls only while `tclk_o` is 0. The test clock never rises while `ten_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transaction request, sampled while idle |
| we_i | input | 1 | 1 = write, 0 = read |
| code_i | input | 8 | Test code selecting the PHY register |
| wdata_i | input | 8 | Data byte for a write |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Monitored or read byte |
| tclk_o | output | 1 | Test clock to the PHY |
| ten_o | output | 1 | Test enable to the PHY |
| tdin_o | output | 8 | Test data-in bus to the PHY |
| tdout_i | input | 8 | Test data-out bus from the PHY |

## Verification
The hardest case to reach is a request that arrives in the middle of a transaction. It must leave no trace, and the only way to see that is that nothing extra happens later. The stimulus raises `req_i` with a different code and direction several cycles into an active write. It then waits longer than a full transaction to confirm that no second completion follows. Finally it reads back the code of the ignored request through the port and checks that the value has not changed. A behavioural PHY responder latches the code on the falling test clock with enable high and stores data on the next rising clock. Read-modify and write results therefore depend on the pin order being right, and not only on the timing.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_C_CLKH,
    ST_C_DIN,
    ST_C_ENH,
    ST_C_CLKL,
    ST_C_ENL,
    ST_D_CLKL,
    ST_D_DIN,
    ST_D_CLKH
  } step_e;

  typedef struct packed {
    logic       set_clk;
    logic       clk_v;
    logic       set_en;
    logic       en_v;
    logic       set_din;
    logic [7:0] din_v;
  } pin_cmd_t;
endpackage

// File: rtl/ptm_dwell_timer.sv
module ptm_dwell_timer #(
  parameter int DWELL_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic active_i,
  output logic tick_o
);
  localparam int CW = (DWELL_CYCLES < 2) ? 1 : $clog2(DWELL_CYCLES);
  localparam logic [CW-1:0] RELOAD = CW'(DWELL_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= RELOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = active_i && (cnt_q == '0);

  assert_cnt_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= RELOAD);
  assert_load_restarts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && DWELL_CYCLES > 1) |=> !tick_o);
endmodule

// File: rtl/ptm_pin_drv.sv
module ptm_pin_drv
  import ptm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  pin_cmd_t   cmd_i,
  output logic       tclk_o,
  output logic       ten_o,
  output logic [7:0] tdin_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tclk_o <= 1'b0;
      ten_o  <= 1'b0;
      tdin_o <= '0;
    end else begin
      if (cmd_i.set_clk) tclk_o <= cmd_i.clk_v;
      if (cmd_i.set_en)  ten_o  <= cmd_i.en_v;
      if (cmd_i.set_din) tdin_o <= cmd_i.din_v;
    end
  end

  assert_en_rise_clk_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ten_o) |-> tclk_o);
  assert_en_fall_clk_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ten_o) |-> !tclk_o);
  assert_no_clk_rise_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tclk_o) |-> !ten_o);
endmodule

// File: rtl/ptm_seq.sv
module ptm_seq
  import ptm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       we_i,
  input  logic [7:0] code_i,
  input  logic [7:0] wdata_i,
  input  logic       tick_i,
  input  logic [7:0] tdout_i,
  output pin_cmd_t   cmd_o,
  output logic       load_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rdata_o
);
  step_e      state_q, state_d;
  logic       we_q;
  logic [7:0] code_q, wdata_q, cap_q;
  logic       accept;

  assign busy_o = (state_q != ST_IDLE);
  assign accept = req_i && !busy_o;
  assign load_o = accept || tick_i;

  always_comb begin
    cmd_o   = '0;
    state_d = state_q;
    if (accept) begin
      cmd_o.set_clk = 1'b1; cmd_o.clk_v = 1'b1;
      state_d       = ST_C_CLKH;
    end else if (tick_i) begin
      unique case (state_q)
        ST_C_CLKH: begin cmd_o.set_din = 1'b1; cmd_o.din_v = code_q; state_d = ST_C_DIN;  end
        ST_C_DIN:  begin cmd_o.set_en  = 1'b1; cmd_o.en_v  = 1'b1;   state_d = ST_C_ENH;  end
        ST_C_ENH:  begin cmd_o.set_clk = 1'b1; cmd_o.clk_v = 1'b0;   state_d = ST_C_CLKL; end
        ST_C_CLKL: begin cmd_o.set_en  = 1'b1; cmd_o.en_v  = 1'b0;   state_d = ST_C_ENL;  end
        ST_C_ENL:  begin cmd_o.set_clk = 1'b1; cmd_o.clk_v = 1'b0;   state_d = ST_D_CLKL; end
        ST_D_CLKL: begin
          cmd_o.set_din = 1'b1;
          cmd_o.din_v   = we_q ? wdata_q : cap_q;
          state_d       = ST_D_DIN;
        end
        ST_D_DIN:  begin cmd_o.set_clk = 1'b1; cmd_o.clk_v = 1'b1;   state_d = ST_D_CLKH; end
        ST_D_CLKH: state_d = ST_IDLE;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      code_q  <= '0;
      wdata_q <= '0;
      cap_q   <= '0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      state_q <= state_d;
      done_o  <= 1'b0;
      if (accept) begin
        we_q    <= we_i;
        code_q  <= code_i;
        wdata_q <= wdata_i;
      end
      // read: capture right after enable falls, reused as write-back byte
      if (tick_i && state_q == ST_C_ENL && !we_q) cap_q <= tdout_i;
      if (tick_i && state_q == ST_D_CLKH) begin
        done_o  <= 1'b1;
        rdata_o <= we_q ? tdout_i : cap_q;
      end
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_not_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_busy_ends_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_req_busy_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i) |=> $stable(code_q) && $stable(we_q));
endmodule

// File: rtl/phy_test_master.sv
module phy_test_master
  import ptm_pkg::*;
#(
  parameter int DWELL_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       we_i,
  input  logic [7:0] code_i,
  input  logic [7:0] wdata_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rdata_o,
  output logic       tclk_o,
  output logic       ten_o,
  output logic [7:0] tdin_o,
  input  logic [7:0] tdout_i
);
  pin_cmd_t cmd;
  logic     load, tick;

  ptm_dwell_timer #(.DWELL_CYCLES(DWELL_CYCLES)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .active_i (busy_o),
    .tick_o   (tick)
  );

  ptm_seq u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .code_i  (code_i),
    .wdata_i (wdata_i),
    .tick_i  (tick),
    .tdout_i (tdout_i),
    .cmd_o   (cmd),
    .load_o  (load),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .rdata_o (rdata_o)
  );

  ptm_pin_drv u_pins (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd),
    .tclk_o (tclk_o),
    .ten_o  (ten_o),
    .tdin_o (tdin_o)
  );

  assert_one_pin_change_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({tclk_o != $past(tclk_o), ten_o != $past(ten_o), tdin_o != $past(tdin_o)}) <= 1);
  assert_hold_in_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick) |=> $stable(tclk_o) && $stable(ten_o) && $stable(tdin_o));
  assert_idle_pins_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !req_i) |=> $stable(tclk_o) && $stable(ten_o) && $stable(tdin_o));
endmodule

// File: tb/phy_test_master_tb.sv
`timescale 1ns/1ps
module phy_test_master_tb;
  localparam int D = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [7:0] code = '0, wdata = '0;
  logic busy, done, tclk, ten;
  logic [7:0] rdata, tdin, tdout;

  int vectors = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  phy_test_master #(.DWELL_CYCLES(D)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .code_i(code),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .tclk_o(tclk), .ten_o(ten), .tdin_o(tdin), .tdout_i(tdout)
  );

  // behavioural PHY test-port responder
  logic [7:0] phy_mem [256];
  logic [7:0] cur_code = '0;
  logic       armed = 1'b0;
  initial for (int i = 0; i < 256; i++) phy_mem[i] = 8'(i) ^ 8'hA5;
  assign tdout = phy_mem[cur_code];

  always @(negedge tclk) if (ten === 1'b1) begin cur_code = tdin; armed = 1'b1; end
  always @(posedge tclk) begin
    if (ten === 1'b1) begin
      vectors++; fails++;
      $display("FAIL R9: test clock rose with enable high (act ten=1 exp ten=0)");
    end else if (armed) begin
      phy_mem[cur_code] = tdin;
      armed = 1'b0;
    end
  end

  // reference model
  logic [7:0] exp_mem [256];
  initial for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i) ^ 8'hA5;
  logic [9:0] q[$];
  logic [9:0] cur = '0;
  logic m_busy = 1'b0, m_done = 1'b0, m_we = 1'b0;
  logic [7:0] m_rdata = '0, pend = '0;

  task automatic push_step(logic c, logic e, logic [7:0] d);
    for (int k = 0; k < D; k++) q.push_back({c, e, d});
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); cur = '0; m_busy = 0; m_done = 0; m_rdata = '0;
    end else begin
      m_done = 1'b0;
      if (q.size() > 0) cur = q.pop_front();
      else if (m_busy) begin m_busy = 0; m_done = 1; m_rdata = pend; end
      else if (req) begin
        logic [7:0] rv;
        rv   = we ? wdata : exp_mem[code];
        m_we = we;
        pend = rv;
        exp_mem[code] = rv;
        push_step(1'b1, 1'b0, cur[7:0]);
        push_step(1'b1, 1'b0, code);
        push_step(1'b1, 1'b1, code);
        push_step(1'b0, 1'b1, code);
        push_step(1'b0, 1'b0, code);
        push_step(1'b0, 1'b0, code);
        push_step(1'b0, 1'b0, rv);
        push_step(1'b1, 1'b0, rv);
        m_busy = 1'b1;
        cur = q.pop_front();
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R2/R3/R6 pins", {tclk, ten, tdin}, cur);
    check("R7/R8 busy", busy, m_busy);
    check("R8 done", done, m_done);
    if (m_done) check(m_we ? "R4 write monitor" : "R5 read value", rdata, m_rdata);
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: act=hung exp=finished");
      summary();
    end
  end

  task automatic do_op(logic w, logic [7:0] c, logic [7:0] d, logic [7:0] exp_r, string tag);
    @(negedge clk); req = 1'b1; we = w; code = c; wdata = d;
    @(negedge clk); req = 1'b0;
    while (!done) @(negedge clk);
    check(tag, rdata, exp_r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 tclk", tclk, 0); check("R1 ten", ten, 0); check("R1 tdin", tdin, 0);
    check("R1 busy", busy, 0); check("R1 done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {tclk, ten, tdin, busy, done}, 0);

    do_op(1'b1, 8'h44, 8'h2A, 8'h2A, "R4 write echo");
    check("R3 clock left high", tclk, 1);
    do_op(1'b0, 8'h44, 8'h00, 8'h2A, "R5 read back written");
    do_op(1'b0, 8'h10, 8'h77, 8'hB5, "R5 read default");
    do_op(1'b0, 8'h10, 8'h00, 8'hB5, "R5 read write-back kept value");
    do_op(1'b1, 8'h00, 8'hFF, 8'hFF, "R4 write code 00");
    do_op(1'b1, 8'hFF, 8'h00, 8'h00, "R4 write code FF");
    do_op(1'b0, 8'hFF, 8'h00, 8'h00, "R5 read code FF");

    // R7: request during busy is ignored
    @(negedge clk); req = 1'b1; we = 1'b1; code = 8'h33; wdata = 8'h5C;
    @(negedge clk); req = 1'b0;
    repeat (4) @(negedge clk);
    req = 1'b1; we = 1'b1; code = 8'h66; wdata = 8'h99;
    @(negedge clk); req = 1'b0;
    while (!done) @(negedge clk);
    check("R7 first result", rdata, 8'h5C);
    repeat (10 * D) @(negedge clk);
    check("R7 no second transaction", busy, 0);
    do_op(1'b0, 8'h66, 8'h00, 8'h66 ^ 8'hA5, "R7 ignored write left register");

    // R6: count busy cycles of one transaction
    begin
      int n = 0;
      @(negedge clk); req = 1'b1; we = 1'b0; code = 8'h33;
      @(negedge clk); req = 1'b0;
      while (!done) begin if (busy) n++; @(negedge clk); end
      check("R6 busy length", n, 8 * D);
      check("R5 read after R7 write", rdata, 8'h5C);
    end

    for (int i = 0; i < 20; i++) begin
      logic w; logic [7:0] c, d, e;
      w = 1'($urandom); c = 8'($urandom); d = 8'($urandom);
      e = w ? d : exp_mem[c];
      do_op(w, c, d, e, w ? "R4 mixed write" : "R5 mixed read");
    end

    repeat (5) @(negedge clk);
    summary();
  end
endmodule